// File: doc/BRIEF.md
# Pipeline Precise Exception Commit Controller

This block tracks exceptions through a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and makes them precise. It owns the program counter and three control stage registers: fetch-to-decode, decode-to-execute and execute-to-memory. Each register holds a valid bit, the instruction address and a 2-bit cause code. A cause can enter at fetch, for example from an instruction-fetch fault. Decode can also raise one for the two trap instructions. The cause then rides along with its instruction.

Exceptions commit only in the memory stage. In the cycle an excepting instruction sits there, the block suppresses its side-effect enables. It also empties every younger stage and reloads the PC with the trapping address plus 4. A break-reached pulse marks a committed break. When the execute stage holds an excepting instruction, the two younger stages are emptied and the PC is held. No wrong-path work can therefore slip in behind the trap. The datapath supplies the memory-stage side-effect requests and any branch redirect. The block returns the gated enables and the fetch address.

Top module: `pexc_commit_ctrl`

## Requirements
- R1: The cause code reported for the memory stage is 0 for none, 1 for break and 2 for syscall. Decode sees a trap only when opcode (instruction bits 31:26) is 0. Funct (bits 5:0) then selects the trap: 0x0D is break and 0x0C is syscall. No other instruction raises a cause.
- R2: A nonzero cause supplied with the fetched instruction is kept through decode, even when that instruction is itself a trap.
- R3: Memory read, memory write, register write and cache-sync enables equal their requests only when the memory stage holds a valid instruction with cause 0; otherwise they are all low.
- R4: After a memory-stage commit, the memory stage holds no valid instruction for exactly three cycles. The younger stages are all emptied.
- R5: While the execute stage holds an excepting instruction, the PC does not advance. The fetch and decode stage registers are emptied.
- R6: In the cycle after a commit, the fetch address equals the trapping instruction's address plus 4.
- R7: The break-reached output is high for exactly one cycle, and only when the memory stage commits cause 1.
- R8: The commit redirect and the execute-stage hold both take priority over a branch request in the same cycle.
- R9: Synchronous active-low reset sets the PC to `RESET_PC` and leaves every stage empty, with address 0 and cause 0.
- R10: Valid instructions reach the memory stage in strict program order. The stream continues at the trap address plus 4, with nothing skipped and nothing repeated.
- R11: An empty memory stage reports address 0 and cause 0 and never commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_op_i | input | 6 | Opcode field of the word fetched at `pc_o` |
| fetch_funct_i | input | 6 | Funct field of the word fetched at `pc_o` |
| fetch_cause_i | input | 2 | Cause raised by fetch for that word |
| br_taken_i | input | 1 | Branch redirect request from the datapath |
| br_target_i | input | 32 | Branch target address |
| mem_rd_req_i | input | 1 | Memory-stage read request |
| mem_wr_req_i | input | 1 | Memory-stage write request |
| reg_wr_req_i | input | 1 | Memory-stage register-write request |
| cache_sync_req_i | input | 1 | Memory-stage cache-sync request |
| pc_o | output | 32 | Current fetch address |
| mem_rd_o | output | 1 | Gated memory read enable |
| mem_wr_o | output | 1 | Gated memory write enable |
| reg_wr_o | output | 1 | Gated register-write enable |
| cache_sync_o | output | 1 | Gated cache-sync enable |
| brk_o | output | 1 | Break-reached pulse |
| mem_valid_o | output | 1 | Memory stage holds a valid instruction |
| mem_addr_o | output | 32 | Address of the memory-stage instruction |
| mem_cause_o | output | 2 | Cause of the memory-stage instruction |

## Verification
The assertions check the following on every cycle:
- the flush after a commit and the silence of all side effects behind it;
- the redirect value and the execute-stage PC hold;
- the survival of a fetch cause through decode;
- the single-cycle break pulse and the bubble invariant.

Only the bench scenarios can show that the stream reaching the memory stage stays in program order, with exactly three bubbles after each commit. The same holds for the precedence of a fetch cause over a trap, and for adjacent traps and branch requests that collide with a trap. Those scenarios sweep trap position, trap kind and fetch faults.

// File: rtl/pexc_pkg.sv
// Package: shared cause codes, trap encodings and stage-register layouts.
// Assumes a 32-bit address space and 4-byte instructions.
package pexc_pkg;
    parameter int unsigned ADDR_W     = 32;
    parameter int unsigned INST_BYTES = 4;
    parameter int unsigned FIELD_W    = 6;

    localparam logic [FIELD_W-1:0] OP_SPECIAL = 6'h00;
    localparam logic [FIELD_W-1:0] FN_SYSCALL = 6'h0C;
    localparam logic [FIELD_W-1:0] FN_BREAK   = 6'h0D;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_BRK  = 2'd1,
        CAUSE_SYS  = 2'd2
    } cause_e;

    // Fetch-to-decode register: carries the fields decode inspects.
    typedef struct packed {
        logic                valid;
        logic [ADDR_W-1:0]   addr;
        cause_e              cause;
        logic [FIELD_W-1:0]  op;
        logic [FIELD_W-1:0]  funct;
    } fd_t;

    // Later stage registers: valid, address and cause only.
    typedef struct packed {
        logic                valid;
        logic [ADDR_W-1:0]   addr;
        cause_e              cause;
    } tag_t;
endpackage

// File: rtl/pexc_stage_reg.sv
// Module: one pipeline stage register with synchronous reset and flush.
// Assumes an all-zero value is a bubble (valid low, address 0, cause none).
module pexc_stage_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Capture the next stage contents, or a bubble on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) q_o <= '0;
        else                   q_o <= d_i;
    end
endmodule

// File: rtl/pexc_trap_decode.sv
// Module: decode-stage cause resolution.
// An inherited cause wins; otherwise a trap encoding raises break or syscall.
// Assumes an invalid stage never raises anything.
module pexc_trap_decode
    import pexc_pkg::*;
(
    input  logic               valid_i,
    input  logic [FIELD_W-1:0] op_i,
    input  logic [FIELD_W-1:0] funct_i,
    input  cause_e             in_cause_i,
    output cause_e             cause_o
);
    // Pick the cause carried forward by the decoded instruction.
    always_comb begin
        cause_o = CAUSE_NONE;
        if (valid_i) begin
            if (in_cause_i != CAUSE_NONE)                    cause_o = in_cause_i;
            else if (op_i == OP_SPECIAL && funct_i == FN_BREAK)   cause_o = CAUSE_BRK;
            else if (op_i == OP_SPECIAL && funct_i == FN_SYSCALL) cause_o = CAUSE_SYS;
        end
    end
endmodule

// File: rtl/pexc_pc_sel.sv
// Module: next-PC selection.
// Priority: commit redirect, then execute-stage hold, then branch, then sequential.
module pexc_pc_sel
    import pexc_pkg::*;
(
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              commit_i,
    input  logic [ADDR_W-1:0] commit_addr_i,
    input  logic              hold_i,
    input  logic              br_taken_i,
    input  logic [ADDR_W-1:0] br_target_i,
    output logic [ADDR_W-1:0] pc_next_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

    // Resolve the competing next-PC sources.
    always_comb begin
        if (commit_i)        pc_next_o = commit_addr_i + STEP;
        else if (hold_i)     pc_next_o = pc_i;
        else if (br_taken_i) pc_next_o = br_target_i;
        else                 pc_next_o = pc_i + STEP;
    end
endmodule

// File: rtl/pexc_commit_ctrl.sv
// Module: precise exception commit controller (top).
// Tracks valid/address/cause through the fetch-to-decode, decode-to-execute and
// execute-to-memory registers. It commits exceptions in the memory stage, gates
// their side effects, flushes younger stages and redirects the PC.
// Assumes the datapath presents the fields of the word at pc_o in the same cycle.
module pexc_commit_ctrl
    import pexc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [5:0]         fetch_op_i,
    input  logic [5:0]         fetch_funct_i,
    input  logic [1:0]         fetch_cause_i,
    input  logic               br_taken_i,
    input  logic [31:0]        br_target_i,
    input  logic               mem_rd_req_i,
    input  logic               mem_wr_req_i,
    input  logic               reg_wr_req_i,
    input  logic               cache_sync_req_i,
    output logic [31:0]        pc_o,
    output logic               mem_rd_o,
    output logic               mem_wr_o,
    output logic               reg_wr_o,
    output logic               cache_sync_o,
    output logic               brk_o,
    output logic               mem_valid_o,
    output logic [31:0]        mem_addr_o,
    output logic [1:0]         mem_cause_o
);
    localparam int unsigned TAG_STAGES = 2;   // 0: decode-to-execute, 1: execute-to-memory
    localparam int unsigned SIDX_EX    = 0;
    localparam int unsigned SIDX_MEM   = 1;

    logic [ADDR_W-1:0] pc_q, pc_next;
    fd_t               fd_q, fd_d;
    tag_t              tag_q [TAG_STAGES];
    tag_t              tag_d [TAG_STAGES];
    logic              tag_flush [TAG_STAGES];
    cause_e            dec_cause;
    logic              mem_exc, exe_exc, mem_clean;

    // Classify the exception state of the memory and execute stages.
    always_comb begin
        mem_exc   = tag_q[SIDX_MEM].valid && tag_q[SIDX_MEM].cause != CAUSE_NONE;
        exe_exc   = tag_q[SIDX_EX].valid  && tag_q[SIDX_EX].cause  != CAUSE_NONE;
        mem_clean = tag_q[SIDX_MEM].valid && tag_q[SIDX_MEM].cause == CAUSE_NONE;
    end

    // Resolve the decode-stage cause.
    pexc_trap_decode u_dec (
        .valid_i    (fd_q.valid),
        .op_i       (fd_q.op),
        .funct_i    (fd_q.funct),
        .in_cause_i (fd_q.cause),
        .cause_o    (dec_cause)
    );

    // Build the fetch-stage capture and the later stage inputs.
    always_comb begin
        fd_d.valid = 1'b1;
        fd_d.addr  = pc_q;
        fd_d.cause = cause_e'(fetch_cause_i);
        fd_d.op    = fetch_op_i;
        fd_d.funct = fetch_funct_i;
        tag_d[SIDX_EX].valid  = fd_q.valid;
        tag_d[SIDX_EX].addr   = fd_q.addr;
        tag_d[SIDX_EX].cause  = dec_cause;
        tag_d[SIDX_MEM]       = tag_q[SIDX_EX];
        tag_flush[SIDX_EX]    = mem_exc || exe_exc;
        tag_flush[SIDX_MEM]   = mem_exc;
    end

    pexc_stage_reg #(.W($bits(fd_t))) u_fd_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (mem_exc || exe_exc),
        .d_i     (fd_d),
        .q_o     (fd_q)
    );

    for (genvar s = 0; s < TAG_STAGES; s++) begin : g_tag
        pexc_stage_reg #(.W($bits(tag_t))) u_tag_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush_i (tag_flush[s]),
            .d_i     (tag_d[s]),
            .q_o     (tag_q[s])
        );
    end

    pexc_pc_sel u_pc_sel (
        .pc_i          (pc_q),
        .commit_i      (mem_exc),
        .commit_addr_i (tag_q[SIDX_MEM].addr),
        .hold_i        (exe_exc),
        .br_taken_i    (br_taken_i),
        .br_target_i   (br_target_i),
        .pc_next_o     (pc_next)
    );

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_next;
    end

    // Gate memory-stage side effects and report the stage contents.
    always_comb begin
        pc_o         = pc_q;
        mem_rd_o     = mem_rd_req_i     && mem_clean;
        mem_wr_o     = mem_wr_req_i     && mem_clean;
        reg_wr_o     = reg_wr_req_i     && mem_clean;
        cache_sync_o = cache_sync_req_i && mem_clean;
        brk_o        = tag_q[SIDX_MEM].valid && tag_q[SIDX_MEM].cause == CAUSE_BRK;
        mem_valid_o  = tag_q[SIDX_MEM].valid;
        mem_addr_o   = tag_q[SIDX_MEM].addr;
        mem_cause_o  = tag_q[SIDX_MEM].cause;
    end

    // R4
    mem_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_exc |=> !tag_q[SIDX_MEM].valid && !tag_q[SIDX_EX].valid && !fd_q.valid);

    // R3
    no_effect_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_exc |=> !(mem_rd_o || mem_wr_o || reg_wr_o || cache_sync_o));

    // R6
    redirect_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_exc |=> pc_o == $past(mem_addr_o) + ADDR_W'(INST_BYTES));

    // R5
    exe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_exc && !mem_exc) |=> pc_o == $past(pc_o) && !fd_q.valid && !tag_q[SIDX_EX].valid);

    // R2
    fetch_cause_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fd_q.valid && fd_q.cause != CAUSE_NONE && !mem_exc && !exe_exc)
        |=> tag_q[SIDX_EX].valid && tag_q[SIDX_EX].cause == $past(fd_q.cause));

    // R7
    brk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |=> !brk_o);

    // R11
    bubble_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid_o |-> mem_cause_o == 2'd0 && mem_addr_o == '0 && !brk_o);
endmodule

// File: tb/pexc_commit_ctrl_bench.sv
module pexc_commit_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op_w, fn_w;
    logic [1:0]  fcause_w;
    logic        br_w;
    logic        rd_req = 1'b0, wr_req = 1'b0, rw_req = 1'b0, cs_req = 1'b0;
    logic [31:0] pc_o, mem_addr_o;
    logic        mem_rd_o, mem_wr_o, reg_wr_o, cache_sync_o, brk_o, mem_valid_o;
    logic [1:0]  mem_cause_o;

    // Scenario knobs
    logic [31:0] t1 = 32'hFFFF_FFF0, t2 = 32'hFFFF_FFF0, fa = 32'hFFFF_FFF0;
    logic [1:0]  t1k = 2'd0, t2k = 2'd0, fk = 2'd0;
    logic        armed = 1'b0;
    localparam logic [31:0] BR_TARGET = 32'h0000_0800;

    int errors = 0, checks = 0, total_cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    function automatic logic [1:0] trap_kind(input logic [31:0] a);
        if (a == t1) return t1k;
        if (a == t2) return t2k;
        return 2'd0;
    endfunction

    function automatic logic [1:0] exp_cause(input logic [31:0] a);
        if (fk != 2'd0 && a == fa) return fk;
        return trap_kind(a);
    endfunction

    // Instruction memory: trap words use opcode 0, funct 0x0D/0x0C; others funct 0x20.
    always_comb begin
        op_w     = 6'h00;
        fn_w     = (trap_kind(pc_o) == 2'd1) ? 6'h0D : (trap_kind(pc_o) == 2'd2) ? 6'h0C : 6'h20;
        fcause_w = (fk != 2'd0 && pc_o == fa) ? fk : 2'd0;
        br_w     = armed && (pc_o == t1 + 32'd8);
    end

    pexc_commit_ctrl u_pexc_commit_ctrl (
        .clk(clk), .rst_n(rst_n),
        .fetch_op_i(op_w), .fetch_funct_i(fn_w), .fetch_cause_i(fcause_w),
        .br_taken_i(br_w), .br_target_i(BR_TARGET),
        .mem_rd_req_i(rd_req), .mem_wr_req_i(wr_req),
        .reg_wr_req_i(rw_req), .cache_sync_req_i(cs_req),
        .pc_o(pc_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .reg_wr_o(reg_wr_o),
        .cache_sync_o(cache_sync_o), .brk_o(brk_o), .mem_valid_o(mem_valid_o),
        .mem_addr_o(mem_addr_o), .mem_cause_o(mem_cause_o)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_case(input logic [31:0] a1, input logic [1:0] k1,
                            input logic [31:0] a2, input logic [1:0] k2,
                            input logic [31:0] f,  input logic [1:0] fkind,
                            input logic br_en);
        logic [31:0] exp_addr = 0;
        logic [31:0] pend_addr = 0;
        logic [1:0]  ec;
        logic        pend = 1'b0, in_gap = 1'b0, disarm = 1'b0;
        int          gap = 0;
        t1 = a1; t1k = k1; t2 = a2; t2k = k2; fa = f; fk = fkind; armed = br_en;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(pc_o == 32'd0 && !mem_valid_o && mem_addr_o == 0 && mem_cause_o == 0,
            "R9 reset", pc_o, 32'd0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 120 && exp_addr < 32'd64; cyc++) begin
            @(negedge clk);
            total_cycles++;
            if (disarm) armed = 1'b0;
            if (pend) begin
                chk(pc_o == pend_addr + 32'd4, "R6 redirect", pc_o, pend_addr + 32'd4);
                pend = 1'b0;
            end
            if (mem_valid_o) begin
                if (in_gap) begin
                    chk(gap == 3, "R4 flush gap", gap, 3);
                    in_gap = 1'b0;
                end
                chk(mem_addr_o == exp_addr, "R10 order", mem_addr_o, exp_addr);
                ec = exp_cause(mem_addr_o);
                chk(mem_cause_o == ec, (fk != 0 && mem_addr_o == fa) ? "R2 fetch cause" : "R1 cause",
                    mem_cause_o, ec);
                chk({mem_rd_o, mem_wr_o, reg_wr_o, cache_sync_o} ==
                    ((ec == 0) ? {rd_req, wr_req, rw_req, cs_req} : 4'b0000),
                    "R3 gating", {mem_rd_o, mem_wr_o, reg_wr_o, cache_sync_o},
                    (ec == 0) ? {rd_req, wr_req, rw_req, cs_req} : 4'b0000);
                chk(brk_o == (ec == 2'd1), "R7 break pulse", brk_o, (ec == 2'd1));
                if (ec != 0) begin
                    chk(pc_o == mem_addr_o + 32'd8, br_en ? "R8 hold over branch" : "R5 hold",
                        pc_o, mem_addr_o + 32'd8);
                    pend = 1'b1; pend_addr = mem_addr_o;
                    in_gap = 1'b1; gap = 0; disarm = 1'b1;
                end
                exp_addr = exp_addr + 32'd4;
            end else begin
                chk(mem_cause_o == 0 && mem_addr_o == 0 && !brk_o &&
                    !(mem_rd_o || mem_wr_o || reg_wr_o || cache_sync_o),
                    "R11 bubble", {mem_cause_o, brk_o}, 0);
                if (in_gap) gap++;
            end
            // New request pattern for the next cycle
            rd_req = cyc[0]; wr_req = ~cyc[0]; rw_req = 1'b1; cs_req = cyc[1];
        end
        chk(exp_addr >= 32'd64, "R10 stream completes", exp_addr, 32'd64);
    endtask

    initial begin
        // No-trap baseline
        run_case(32'hFFFF_FFF0, 0, 32'hFFFF_FFF0, 0, 32'hFFFF_FFF0, 0, 1'b0);
        // Single traps at every position, both kinds, branch collision on odd slots
        for (int p = 0; p < 8; p++) begin
            for (int k = 1; k <= 2; k++) begin
                run_case(32'(p * 4 + 4), 2'(k), 32'hFFFF_FFF0, 0, 32'hFFFF_FFF0, 0, p[0]);
            end
        end
        run_case(32'd0, 2'd1, 32'hFFFF_FFF0, 0, 32'hFFFF_FFF0, 0, 1'b1);
        // Adjacent traps
        run_case(32'd8, 2'd1, 32'd12, 2'd2, 32'hFFFF_FFF0, 0, 1'b0);
        run_case(32'd20, 2'd2, 32'd24, 2'd1, 32'hFFFF_FFF0, 0, 1'b1);
        // Fetch cause over a syscall word, and on an ordinary word
        run_case(32'd16, 2'd2, 32'hFFFF_FFF0, 0, 32'd16, 2'd1, 1'b0);
        run_case(32'hFFFF_FFF0, 0, 32'hFFFF_FFF0, 0, 32'd20, 2'd2, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", total_cycles, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule